// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Lock Flag

This block compares two single-cycle edge strobes, one from the divided reference and one from the divided feedback of a synthesizer loop. It produces a pair of drive enables for a three-state control pin that steers an external loop filter and oscillator. When the reference edge comes first, or the feedback runs slow, the pin is driven high until the feedback edge arrives. When the feedback edge comes first, or the feedback runs fast, the pin is driven low until the reference edge arrives. When neither correction is needed, the pin floats.

Internally there are two edge-set flags. A reference strobe sets the "advance" flag and a feedback strobe sets the "retard" flag. Once both flags are set, both clear on the next clock. An active-high lock flag stays high while the two edges line up. It drops for exactly the clocks in which only one flag is set, so an unlocked loop shows up as a train of low pulses rather than as a steady low. Strobes that land in the same system clock count as aligned and create no correction. All state is reset synchronously with an active-high reset.

Top module: `phase_freq_det`

## Requirements
- R1: While reset is high, and on the first clock after reset, both drive enables are 0 and `lock_ok` is 1.
- R2: A reference strobe with no feedback strobe, from the idle state, makes `drive_hi_en` 1 and `lock_ok` 0 on the next clock.
- R3: A feedback strobe with no reference strobe, from the idle state, makes `drive_lo_en` 1 and `lock_ok` 0 on the next clock.
- R4: An active drive enable holds, and repeated strobes on the same input leave it unchanged, until a strobe arrives on the other input.
- R5: When the opposing strobe arrives, both enables drop to 0 (the pin floats) and `lock_ok` returns to 1 on the next clock. Both internal flags then clear on the following clock.
- R6: Reference and feedback strobes in the same clock, from idle, produce no drive enable, and `lock_ok` stays 1.
- R7: `drive_hi_en` and `drive_lo_en` are never 1 together.
- R8: A strobe that arrives in the clock where both flags are clearing starts a new comparison. It sets its own flag on that clock edge.
- R9: `lock_ok` is 0 exactly when one drive enable is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | One-clock pulse for each divided reference edge |
| fb_strobe | input | 1 | One-clock pulse for each divided feedback edge |
| drive_hi_en | output | 1 | Drive the control pin high (feedback late or slow) |
| drive_lo_en | output | 1 | Drive the control pin low (feedback early or fast) |
| lock_ok | output | 1 | 1 when aligned, 0 while exactly one flag is set |

## Verification
Every output is decoded straight from the two flag registers, so a wrong flag value shows up at the ports on the very next clock edge. A flag that fails to clear leaves a drive enable stuck, and the lock flag stays low one clock after the matching strobe. A flag that clears too early drops the enable before the opposing strobe arrives. The stimulus walks ordered, reversed, simultaneous and clear-cycle strobe patterns, and compares all three outputs on every clock against values worked out by hand.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int NUM_CH  = 2;
    localparam int CH_ADV  = 0;
    localparam int CH_RET  = 1;

    typedef struct packed {
        logic adv;
        logic ret;
    } flag_pair_t;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'b00,
        DRV_HIGH  = 2'b01,
        DRV_LOW   = 2'b10
    } drive_t;

    typedef struct packed {
        logic hi_en;
        logic lo_en;
        logic lock;
    } det_out_t;

    function automatic drive_t classify(input flag_pair_t f);
        drive_t d;
        unique case ({f.adv, f.ret})
            2'b10:   d = DRV_HIGH;
            2'b01:   d = DRV_LOW;
            default: d = DRV_FLOAT;
        endcase
        return d;
    endfunction

    function automatic det_out_t expand(input drive_t d);
        det_out_t o;
        o.hi_en = (d == DRV_HIGH);
        o.lo_en = (d == DRV_LOW);
        o.lock  = (d == DRV_FLOAT);
        return o;
    endfunction

endpackage

// File: rtl/pfd_edge_flag.sv
module pfd_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic clear,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= strobe | (flag_q & ~clear);
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/pfd_drive_decode.sv
module pfd_drive_decode
    import pfd_pkg::*;
(
    input  flag_pair_t flags,
    output det_out_t   outs
);
    drive_t state;

    always_comb begin
        state = classify(flags);
        outs  = expand(state);
    end
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_strobe,
    input  logic fb_strobe,
    output logic drive_hi_en,
    output logic drive_lo_en,
    output logic lock_ok
);
    logic [NUM_CH-1:0] strobe_vec;
    logic [NUM_CH-1:0] flag_vec;
    logic              both_set;
    flag_pair_t        flags;
    det_out_t          outs;

    assign strobe_vec[CH_ADV] = ref_strobe;
    assign strobe_vec[CH_RET] = fb_strobe;
    assign both_set           = &flag_vec;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        pfd_edge_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe_vec[ch]),
            .clear  (both_set),
            .flag   (flag_vec[ch])
        );
    end

    assign flags.adv = flag_vec[CH_ADV];
    assign flags.ret = flag_vec[CH_RET];

    pfd_drive_decode u_decode (
        .flags (flags),
        .outs  (outs)
    );

    assign drive_hi_en = outs.hi_en;
    assign drive_lo_en = outs.lo_en;
    assign lock_ok     = outs.lock;
endmodule

// File: rtl/phase_freq_det_checker.sv
module phase_freq_det_checker (
    input logic       clk,
    input logic       rst,
    input logic       ref_strobe,
    input logic       fb_strobe,
    input logic       drive_hi_en,
    input logic       drive_lo_en,
    input logic       lock_ok,
    input logic [1:0] flag_vec
);
    wire idle = !drive_hi_en && !drive_lo_en && lock_ok;

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drive_hi_en && drive_lo_en));

    a_r9_lock_map: assert property (@(posedge clk) disable iff (rst)
        lock_ok == !(drive_hi_en || drive_lo_en));

    a_r2_ref_first: assert property (@(posedge clk) disable iff (rst)
        (idle && !(&flag_vec) && ref_strobe && !fb_strobe) |=> (drive_hi_en && !lock_ok));

    a_r3_fb_first: assert property (@(posedge clk) disable iff (rst)
        (idle && !(&flag_vec) && fb_strobe && !ref_strobe) |=> (drive_lo_en && !lock_ok));

    a_r4_hold_hi: assert property (@(posedge clk) disable iff (rst)
        (drive_hi_en && !fb_strobe) |=> drive_hi_en);

    a_r4_hold_lo: assert property (@(posedge clk) disable iff (rst)
        (drive_lo_en && !ref_strobe) |=> drive_lo_en);

    a_r5_clear_both: assert property (@(posedge clk) disable iff (rst)
        (&flag_vec) |=> (flag_vec[0] == $past(ref_strobe) && flag_vec[1] == $past(fb_strobe)));

    a_r6_same_clock: assert property (@(posedge clk) disable iff (rst)
        (flag_vec == 2'b00 && ref_strobe && fb_strobe) |=> (idle && &flag_vec));
endmodule

bind phase_freq_det phase_freq_det_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .ref_strobe  (ref_strobe),
    .fb_strobe   (fb_strobe),
    .drive_hi_en (drive_hi_en),
    .drive_lo_en (drive_lo_en),
    .lock_ok     (lock_ok),
    .flag_vec    (flag_vec)
);

// File: tb/phase_freq_det_test.sv
`timescale 1ns/1ps
module phase_freq_det_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_strobe = 1'b0;
    logic fb_strobe = 1'b0;
    logic drive_hi_en, drive_lo_en, lock_ok;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    phase_freq_det uut (
        .clk         (clk),
        .rst         (rst),
        .ref_strobe  (ref_strobe),
        .fb_strobe   (fb_strobe),
        .drive_hi_en (drive_hi_en),
        .drive_lo_en (drive_lo_en),
        .lock_ok     (lock_ok)
    );

    // {ref, fb, exp_hi, exp_lo, exp_lock}; expected after the clock that takes the strobes
    localparam int NV = 17;
    localparam logic [4:0] VEC [0:NV-1] = '{
        5'b10_100, 5'b00_100, 5'b01_001, 5'b00_001,
        5'b01_010, 5'b10_001, 5'b11_001, 5'b00_001,
        5'b11_001, 5'b00_001, 5'b01_010, 5'b01_010,
        5'b10_001, 5'b10_100, 5'b00_100, 5'b01_001,
        5'b00_001
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:           return "R2";
            1, 11, 14:   return "R4";
            4, 10:       return "R3";
            6, 13:       return "R8";
            8:           return "R6";
            default:     return "R5";
        endcase
    endfunction

    task automatic check3(input string tag, input logic hi, input logic lo, input logic lk);
        checks++;
        if (drive_hi_en !== hi || drive_lo_en !== lo || lock_ok !== lk) begin
            fails++;
            $display("FAIL %s: got hi=%b lo=%b lock=%b, expected hi=%b lo=%b lock=%b",
                     tag, drive_hi_en, drive_lo_en, lock_ok, hi, lo, lk);
        end
        checks++;
        if (drive_hi_en && drive_lo_en) begin
            fails++;
            $display("FAIL R7: got both enables 1, expected at most one");
        end
        checks++;
        if (lock_ok !== !(drive_hi_en || drive_lo_en)) begin
            fails++;
            $display("FAIL R9: got lock=%b, expected %b", lock_ok, !(drive_hi_en || drive_lo_en));
        end
    endtask

    task automatic step(input logic r, input logic f);
        ref_strobe = r;
        fb_strobe  = f;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got run still active, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check3("R1", 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        step(1'b0, 1'b0);
        check3("R1", 1'b0, 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], VEC[i][3]);
            check3(vec_tag(i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R4: long run of feedback-only strobes keeps low drive
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b1);
            check3("R4", 1'b0, 1'b1, 1'b0);
        end
        step(1'b1, 1'b0);
        check3("R5", 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1);
        check3("R8", 1'b0, 1'b1, 1'b0);

        // R1: reset in the middle of a correction
        rst = 1'b1;
        step(1'b0, 1'b0);
        check3("R1", 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        step(1'b0, 1'b0);
        check3("R1", 1'b0, 1'b0, 1'b1);

        // R6: repeated coincident strobes never correct
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b1);
            check3("R6", 1'b0, 1'b0, 1'b1);
        end
        step(1'b0, 1'b0);
        check3("R6", 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0);
        check3("R2", 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule